// File: doc/BRIEF.md
# Flux-Reversal Byte Serializer with Self-Sync Slots

This block turns a stream of bytes from a host into a train of flux-reversal commands on a single write line. The host works only in whole bytes. It presents each byte with a two-bit kind tag on a valid/ready interface, and the block handles all bit-level timing. Each byte takes one slot. A slot is a run of cells of `CELL_CLKS` system-clock cycles each. A 1 cell flips the write line at the start of the cell. A 0 cell leaves the write line unchanged. Bits leave a byte-wide shift register most significant bit first, one per cell.

A data byte fills 8 cells. A self-sync filler byte fills 9 or 10 cells: the 8 bits the host supplied, followed by one or two 0 cells. The host chooses the slot length for each byte through the kind tag.

Back-pressure rules: while writing, `in_ready` is high only during the last cell of the current slot, and only until one byte has been staged. A byte accepted there starts at the next slot boundary with no gap. If no byte is present at a boundary, the block writes an 8-cell slot of zeros and raises `underrun`. When the block is idle, `in_ready` follows the write enable. While the write enable is low, `in_ready` stays low.

Top module: `flux_byte_writer`

## Requirements
- R1: After reset, `wr_flux` is 0, `underrun` is 0, and `in_ready` is 0 while `wr_en` is low.
- R2: One cell lasts `CELL_CLKS` cycles. The slot length depends on `in_kind`: 2'b00 or 2'b11 gives a data slot of 8 cells, 2'b01 gives 9 cells, and 2'b10 gives 10 cells.
- R3: The byte bits are written MSB first, one per cell. A 1 bit flips `wr_flux` at the start of its cell. A 0 bit leaves it unchanged. `wr_flux` changes at no other time.
- R4: The extra cells of a 9-cell or 10-cell slot come after the 8 data bits and are always 0, so they cause no flip.
- R5: When idle with `wr_en` high, `in_ready` is 1. An accepted byte's first cell begins at the accepting clock edge, so a leading 1 bit shows on `wr_flux` in the next cycle.
- R6: While writing, `in_ready` is 1 only during the last cell of the current slot and only while no byte is staged. A byte waiting there is accepted in the first cycle of that cell, and its slot begins exactly at the slot boundary.
- R7: If `wr_en` is high and no byte is staged or offered at a slot boundary, the block writes an 8-cell slot of 0 cells and `underrun` rises at that boundary. A host byte can be accepted in the last cell of that slot, and `underrun` falls when the host byte's slot starts.
- R8: While `wr_en` is low, `wr_flux` does not change and `in_ready` is 0. At the next cell boundary after `wr_en` drops, writing stops, the block returns to idle, `underrun` clears, and any staged byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable; low stops writing at the next cell boundary |
| in_valid | input | 1 | Host byte offered |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| in_data | input | 8 | Byte to write, MSB first |
| in_kind | input | 2 | Slot kind: 00/11 data (8 cells), 01 sync (9), 10 sync (10) |
| wr_flux | output | 1 | Write line; flips for each 1 cell |
| underrun | output | 1 | High during a zero slot inserted for lack of a host byte |

## Verification
The main stream sends six back-to-back bytes covering all four kind codes. Every byte has its MSB set, so each slot start shows up as a flip. This separates errors in slot framing from errors in bit order or in the flip pattern. The all-ones sync bytes show whether the trailing cells stay 0 and whether the 9-cell and 10-cell slots have their own lengths. The mixed patterns 0xD5, 0x96 and 0xA7 catch reversed bit order and extra or missing flips. Handshake cycles are compared against slot boundaries to detect a gap, or an early or late ready. Separate runs cover starvation into an underrun slot, recovery from it, a stop in the middle of a slot that must drop the rest of the byte, and a cold start from idle, where the latency to the first flip is measured.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned SLOT_W    = 4;

  typedef enum logic [1:0] {
    KIND_DATA     = 2'b00,
    KIND_SYNC9    = 2'b01,
    KIND_SYNC10   = 2'b10,
    KIND_DATA_ALT = 2'b11
  } byte_kind_e;

  // Number of cells a slot of the given kind occupies
  function automatic logic [SLOT_W-1:0] slot_cells(input logic [1:0] kind);
    case (byte_kind_e'(kind))
      KIND_SYNC9:  return SLOT_W'(BYTE_BITS + 1);
      KIND_SYNC10: return SLOT_W'(BYTE_BITS + 2);
      default:     return SLOT_W'(BYTE_BITS);
    endcase
  endfunction
endpackage

// File: rtl/fbw_cell_timer.sv
module fbw_cell_timer #(
  parameter int unsigned CELL_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CELL_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fbw_slot_ctrl.sv
module fbw_slot_ctrl
  import fbw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 tick,
  input  logic                 in_valid,
  input  logic [BYTE_BITS-1:0] in_data,
  input  logic [1:0]           in_kind,
  output logic                 in_ready,
  output logic                 run,
  output logic                 load,
  output logic                 adv,
  output logic [BYTE_BITS-1:0] load_byte,
  output logic                 underrun
);
  logic                 run_q, stg_full, und_q, starve;
  logic [BYTE_BITS-1:0] stg_byte;
  logic [SLOT_W-1:0]    stg_len, cell_idx, slot_len, load_len;
  logic                 last_cell, take, stop, boundary;

  assign last_cell = run_q && (cell_idx == slot_len - 1'b1);
  assign in_ready  = wr_en && (!run_q || (last_cell && !stg_full));
  assign take      = in_valid && in_ready;
  assign stop      = run_q && tick && !wr_en;
  assign boundary  = run_q && tick && wr_en && last_cell;
  assign adv       = run_q && tick && wr_en && !last_cell;
  assign run       = run_q;
  assign underrun  = und_q;

  always_comb begin
    load      = 1'b0;
    load_byte = '0;
    load_len  = SLOT_W'(BYTE_BITS);
    starve    = 1'b0;
    if (!run_q && take) begin
      load      = 1'b1;
      load_byte = in_data;
      load_len  = slot_cells(in_kind);
    end else if (boundary) begin
      load = 1'b1;
      if (stg_full) begin
        load_byte = stg_byte;
        load_len  = stg_len;
      end else if (take) begin
        load_byte = in_data;
        load_len  = slot_cells(in_kind);
      end else begin
        starve = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cell_idx <= '0;
      slot_len <= SLOT_W'(BYTE_BITS);
      stg_full <= 1'b0;
      stg_byte <= '0;
      stg_len  <= SLOT_W'(BYTE_BITS);
      und_q    <= 1'b0;
    end else begin
      if (stop)      run_q <= 1'b0;
      else if (load) run_q <= 1'b1;

      if (load)     cell_idx <= '0;
      else if (adv) cell_idx <= cell_idx + 1'b1;

      if (load) slot_len <= load_len;

      if (stop || boundary)  stg_full <= 1'b0;
      else if (take && run_q) stg_full <= 1'b1;

      if (take) begin
        stg_byte <= in_data;
        stg_len  <= slot_cells(in_kind);
      end

      if (stop)      und_q <= 1'b0;
      else if (load) und_q <= starve;
    end
  end

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !wr_en) |=> (!run_q && !in_ready && !und_q));

  // R2
  cell_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(cell_idx));

  // R2
  sync10_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && take && in_kind == 2'b10) |=> (slot_len == SLOT_W'(10)));

  // R7
  starve_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !stg_full && !in_valid) |=> (und_q && run_q && cell_idx == '0));

  // R6
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && in_ready) |-> (cell_idx == slot_len - 1'b1));
endmodule

// File: rtl/fbw_flux_shift.sv
module fbw_flux_shift
  import fbw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 adv,
  input  logic [BYTE_BITS-1:0] load_byte,
  output logic                 wr_flux
);
  logic [BYTE_BITS-1:0] sh;
  logic                 flux_q;

  assign wr_flux = flux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      flux_q <= 1'b0;
    end else if (load) begin
      flux_q <= flux_q ^ load_byte[BYTE_BITS-1];
      sh     <= {load_byte[BYTE_BITS-2:0], 1'b0};
    end else if (adv) begin
      flux_q <= flux_q ^ sh[BYTE_BITS-1];
      sh     <= {sh[BYTE_BITS-2:0], 1'b0};
    end
  end

  // R3
  flux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || adv) |=> $stable(flux_q));
endmodule

// File: rtl/flux_byte_writer.sv
module flux_byte_writer
  import fbw_pkg::*;
#(
  parameter int unsigned CELL_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] in_kind,
  output logic       wr_flux,
  output logic       underrun
);
  logic                 run, tick, load, adv;
  logic [BYTE_BITS-1:0] load_byte;

  fbw_cell_timer #(.CELL_CLKS(CELL_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  fbw_slot_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick),
    .in_valid(in_valid), .in_data(in_data), .in_kind(in_kind),
    .in_ready(in_ready), .run(run), .load(load), .adv(adv),
    .load_byte(load_byte), .underrun(underrun)
  );

  fbw_flux_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .load_byte(load_byte), .wr_flux(wr_flux)
  );

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_flux));
endmodule

// File: tb/flux_byte_writer_bench.sv
`timescale 1ns/1ps
module flux_byte_writer_bench;
  localparam int C  = 8;
  localparam int NV = 6;
  // {kind[1:0], data[7:0]}; every byte has its MSB set so each slot start flips
  localparam logic [9:0] VEC [NV] = '{10'h0D5, 10'h1FF, 10'h2FF, 10'h396, 10'h1A7, 10'h0FF};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_kind = '0;
  wire in_ready, wr_flux, underrun;

  flux_byte_writer #(.CELL_CLKS(C)) u_flux_byte_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .wr_flux(wr_flux), .underrun(underrun)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tog_t [512];
  int ntog = 0;
  logic prev_f = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (wr_flux !== prev_f) begin
      if (ntog < 512) tog_t[ntog] = cyc;
      ntog++;
    end
    prev_f = wr_flux;
  end

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d, output int hcyc);
    int g = 0;
    in_valid = 1'b1; in_kind = k; in_data = d;
    while (!in_ready && g < 4000) begin step(); g++; end
    hcyc = cyc;
    step();
    in_valid = 1'b0;
  endtask

  function automatic int len_of(input logic [1:0] k);
    return (k == 2'b01) ? 9 : (k == 2'b10) ? 10 : 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h [NV];
    int start [NV];
    int exp_c [96];
    int ne, s, t0, base, ur_cyc, n1, hu, n3, hi, g;

    // R1 reset state
    repeat (3) step();
    chk(wr_flux == 1'b0, "R1 flux", wr_flux, 0);
    chk(underrun == 1'b0, "R1 underrun", underrun, 0);
    chk(in_ready == 1'b0, "R1 ready", in_ready, 0);
    rst_n = 1'b1;
    step();
    chk(in_ready == 1'b0, "R8 ready with wr_en low", in_ready, 0);
    wr_en = 1'b1;
    step();
    chk(in_ready == 1'b1, "R5 idle ready", in_ready, 1);

    // vector table walked by one loop
    base = ntog;
    ne = 0; s = 0;
    for (int i = 0; i < NV; i++) begin
      start[i] = s;
      for (int k = 0; k < 8; k++) if (VEC[i][7-k]) begin exp_c[ne] = s + k; ne++; end
      s += len_of(VEC[i][9:8]);
      send(VEC[i][9:8], VEC[i][7:0], h[i]);
    end
    t0 = h[0] + 1;
    chk(underrun == 1'b0, "R7 no underrun while fed", underrun, 0);
    g = 0;
    while (!underrun && g < 2000) begin step(); g++; end
    ur_cyc = cyc;

    for (int i = 1; i < NV; i++)
      chk(h[i] == t0 + (start[i] - 1) * C, "R2 R6 handshake at last cell", h[i], t0 + (start[i] - 1) * C);
    chk(ntog - base == ne, "R3 R4 flip count", ntog - base, ne);
    for (int j = 0; j < ne; j++)
      chk(tog_t[base + j] == t0 + exp_c[j] * C, "R3 flip position", tog_t[base + j], t0 + exp_c[j] * C);
    chk(ur_cyc == t0 + s * C, "R7 underrun onset", ur_cyc, t0 + s * C);

    // underrun slot then recovery
    n1 = ntog;
    send(2'b00, 8'h81, hu);
    chk(hu == t0 + (s + 7) * C, "R7 ready in last zero cell", hu, t0 + (s + 7) * C);
    chk(ntog == n1, "R7 zero slot silent", ntog, n1);
    g = 0;
    while (ntog == n1 && g < 2000) begin step(); g++; end
    chk(tog_t[n1] == t0 + (s + 8) * C, "R7 recovery slot start", tog_t[n1], t0 + (s + 8) * C);
    chk(underrun == 1'b0, "R7 underrun cleared", underrun, 0);
    chk(in_ready == 1'b0, "R6 ready low mid slot", in_ready, 0);

    // stop mid slot: the trailing 1 of 0x81 must never be written
    wr_en = 1'b0;
    repeat (12 * C) step();
    chk(ntog == n1 + 1, "R8 stop drops rest of byte", ntog, n1 + 1);
    chk(in_ready == 1'b0, "R8 ready low when off", in_ready, 0);
    chk(underrun == 1'b0, "R8 underrun cleared on stop", underrun, 0);
    wr_en = 1'b1;
    step();
    chk(in_ready == 1'b1, "R5 back to idle", in_ready, 1);

    // cold start latency, then stop after three cells
    n3 = ntog;
    send(2'b00, 8'hFF, hi);
    chk(ntog == n3 + 1, "R5 first flip count", ntog, n3 + 1);
    chk(tog_t[n3] == hi + 1, "R5 first flip latency", tog_t[n3], hi + 1);
    g = 0;
    while (ntog < n3 + 3 && g < 2000) begin step(); g++; end
    wr_en = 1'b0;
    repeat (12 * C) step();
    chk(ntog == n3 + 3, "R8 stop at cell boundary", ntog, n3 + 3);
    chk(tog_t[n3 + 2] - tog_t[n3 + 1] == C, "R2 cell period", tog_t[n3 + 2] - tog_t[n3 + 1], C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule